// File: doc/BRIEF.md
# Link Controller Power-Up Sequencer

This block brings a serial link controller and its PHY out of power-down in a fixed order after a single start pulse. It switches on the supply and then three clocks, one step per cycle. It releases the PHY power-down and, after a short programmed delay, switches on the reference clock. That delay exists because the PHY's asynchronous reset is synchronised on the reference clock and must see enough of it. The block then lets the clocks settle, drives a pulse on the external endpoint reset pin at a strap-selected active level, and releases the PHY reset. Finally it polls the PLL lock input a bounded number of times.

Every enable step has a failure input. When one reports trouble, the block switches the steps already on back off, newest first, and raises an error flag. All waits count a shared microsecond tick made by a prescaler. The tick rate and each wait length are parameters, so the same block serves fast simulation settings and real millisecond waits.

Top module: `lnk_pwr_seq`

## Requirements
- R1: While in reset or idle, every enable output is 0, `phy_pd_o` is 1, `phy_rst_o` is 1, the flags are 0, and `ep_rst_o` sits at the inactive level, which is the inverse of `rst_pol_i`. A change of the strap while idle is followed on the pin one cycle later.
- R2: A start seen in idle turns on `supply_en_o` at that edge. `phy_clk_en_o`, `bus_clk_en_o` and `core_clk_en_o` follow, one clock cycle apart in that order.
- R3: `phy_pd_o` falls one cycle after `core_clk_en_o` rises. `refclk_en_o` rises exactly REF_DLY_US*TICK_DIV+2 cycles after `phy_pd_o` falls.
- R4: `ep_rst_o` goes to its active level exactly SETTLE_US*TICK_DIV+3 cycles after `refclk_en_o` rises.
- R5: The endpoint reset pulse lasts exactly EP_RST_US*TICK_DIV+2 cycles. Its active level is `rst_pol_i`, where 1 means active high and 0 means active low.
- R6: `phy_rst_o` falls on the same edge at which `ep_rst_o` returns to its inactive level.
- R7: The first lock poll samples `pll_lock_i` in the cycle after `phy_rst_o` falls. Later polls come every POLL_GAP_US*TICK_DIV+3 cycles. `done_o` rises on the edge after a poll that saw lock.
- R8: If POLL_MAX polls all see no lock, `lock_to_o` rises on the edge after the last one. `done_o` stays 0 and all enables stay on.
- R9: Failure input `step_err_i[k]` is sampled in the cycle after enable k rises. The bits are 0 supply, 1 PHY clock, 2 bus clock, 3 core clock, 4 reference clock. If the sampled bit is set, the enables that are on turn off one per cycle, highest bit first, beginning two cycles after enable k rose. On the edge that clears the supply, `phy_pd_o` returns to 1, `err_o` rises and the block goes back to idle.
- R10: Start is acted on only in idle, including idle after a failure, where it also clears `err_o` on the same edge that turns on the supply. A start after `done_o` or `lock_to_o` changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin the power-up sequence (idle only) |
| pll_lock_i | input | 1 | PHY PLL locked status |
| rst_pol_i | input | 1 | Endpoint reset active level strap (1 = active high) |
| step_err_i | input | 5 | Per-step enable failure report |
| supply_en_o | output | 1 | Supply enable |
| phy_clk_en_o | output | 1 | PHY clock enable |
| bus_clk_en_o | output | 1 | Bus clock enable |
| core_clk_en_o | output | 1 | Core clock enable |
| refclk_en_o | output | 1 | Reference clock enable |
| phy_pd_o | output | 1 | PHY power-down, 1 = powered down |
| ep_rst_o | output | 1 | External endpoint reset pin level |
| phy_rst_o | output | 1 | PHY reset, 1 = held in reset |
| done_o | output | 1 | Sequence finished with PLL locked |
| lock_to_o | output | 1 | PLL never locked within the poll budget |
| err_o | output | 1 | An enable step failed and was unwound |

## Verification
The two functions that can fall in the same cycle are the failure check of the reference clock step and the start of the settle wait. Both are decided in the cycle right after `refclk_en_o` rises. The bench provokes this by holding bit 4 of `step_err_i` high, and judges it by requiring that the endpoint reset never goes active and that the reference clock falls two cycles after it rose. A second coincidence is lock arriving in exactly the cycle of a poll, against the last poll of the budget. Lock delays one cycle either side of the final poll must give `done_o` and `lock_to_o` respectively.

// File: rtl/lps_pkg.sv
package lps_pkg;

  typedef enum logic [3:0] {
    ST_IDLE = 4'd0,
    ST_CHK  = 4'd1,
    ST_WREF = 4'd2,
    ST_RCHK = 4'd3,
    ST_SETL = 4'd4,
    ST_EPH  = 4'd5,
    ST_POLL = 4'd6,
    ST_GAP  = 4'd7,
    ST_UNW  = 4'd8,
    ST_UP   = 4'd9,
    ST_LTO  = 4'd10
  } lps_state_e;

  localparam int unsigned LPS_NSTEP     = 5;
  localparam int unsigned LPS_STEP_CORE = 3;
  localparam int unsigned LPS_STEP_REF  = 4;

endpackage

// File: rtl/lps_tick.sv
module lps_tick #(
  parameter int unsigned TICK_DIV = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [PW-1:0] pre_q;

  assign tick_o = (pre_q == PW'(TICK_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      pre_q <= '0;
    end else if (tick_o) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/lps_timer.sv
module lps_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  input  logic          tick_i,
  output logic          done_o
);
  logic [TW-1:0] cnt_q;

  assign done_o = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= val_i;
    end else if (tick_i && !done_o) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/lps_retry.sv
module lps_retry #(
  parameter int unsigned POLL_MAX = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int unsigned RW = (POLL_MAX > 1) ? $clog2(POLL_MAX) : 1;

  logic [RW-1:0] cnt_q;

  assign last_o = (cnt_q == RW'(POLL_MAX - 1));

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_q <= '0;
    end else if (inc_i && !last_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/lnk_pwr_seq.sv
module lnk_pwr_seq
  import lps_pkg::*;
#(
  parameter int unsigned TICK_DIV    = 100,
  parameter int unsigned REF_DLY_US  = 10,
  parameter int unsigned SETTLE_US   = 200,
  parameter int unsigned EP_RST_US   = 100000,
  parameter int unsigned POLL_MAX    = 2000,
  parameter int unsigned POLL_GAP_US = 50
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       pll_lock_i,
  input  logic       rst_pol_i,
  input  logic [4:0] step_err_i,
  output logic       supply_en_o,
  output logic       phy_clk_en_o,
  output logic       bus_clk_en_o,
  output logic       core_clk_en_o,
  output logic       refclk_en_o,
  output logic       phy_pd_o,
  output logic       ep_rst_o,
  output logic       phy_rst_o,
  output logic       done_o,
  output logic       lock_to_o,
  output logic       err_o
);
  localparam int unsigned NW   = LPS_NSTEP;
  localparam int unsigned MA   = (REF_DLY_US > SETTLE_US) ? REF_DLY_US : SETTLE_US;
  localparam int unsigned MB   = (EP_RST_US > POLL_GAP_US) ? EP_RST_US : POLL_GAP_US;
  localparam int unsigned TMAX = (MA > MB) ? MA : MB;
  localparam int unsigned TW   = $clog2(TMAX + 1);

  lps_state_e    st_q;
  logic [2:0]    idx_q;
  logic [NW-1:0] en_q;
  logic          pd_q;
  logic          phy_rst_q;
  logic          ep_q;
  logic          done_q;
  logic          lto_q;
  logic          err_q;
  logic          ld_q;
  logic [TW-1:0] ldv_q;

  logic          tick;
  logic          tmr_done;
  logic          tmr_go;
  logic          rty_last;
  logic          rty_clr;
  logic          rty_inc;
  logic          cur_err;
  logic [NW-1:0] idx_mask;

  lps_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (ld_q),
    .tick_o (tick)
  );

  lps_timer #(.TW(TW)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load_i (ld_q),
    .val_i  (ldv_q),
    .tick_i (tick),
    .done_o (tmr_done)
  );

  lps_retry #(.POLL_MAX(POLL_MAX)) u_retry (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (rty_clr),
    .inc_i  (rty_inc),
    .last_o (rty_last)
  );

  // A wait is over only once the load pulse has reached the timer.
  assign tmr_go   = !ld_q && tmr_done;
  assign rty_clr  = (st_q == ST_IDLE);
  assign rty_inc  = (st_q == ST_POLL) && !pll_lock_i;
  assign idx_mask = NW'(1) << idx_q;
  assign cur_err  = |(step_err_i & idx_mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      idx_q     <= '0;
      en_q      <= '0;
      pd_q      <= 1'b1;
      phy_rst_q <= 1'b1;
      ep_q      <= ~rst_pol_i;
      done_q    <= 1'b0;
      lto_q     <= 1'b0;
      err_q     <= 1'b0;
      ld_q      <= 1'b0;
      ldv_q     <= '0;
    end else begin
      ld_q <= 1'b0;
      ep_q <= ~rst_pol_i;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            en_q  <= NW'(1);
            idx_q <= '0;
            err_q <= 1'b0;
            st_q  <= ST_CHK;
          end
        end
        ST_CHK: begin
          if (cur_err) begin
            st_q <= ST_UNW;
          end else if (idx_q == 3'(LPS_STEP_CORE)) begin
            pd_q  <= 1'b0;
            ld_q  <= 1'b1;
            ldv_q <= TW'(REF_DLY_US);
            st_q  <= ST_WREF;
          end else begin
            en_q  <= en_q | (idx_mask << 1);
            idx_q <= idx_q + 3'd1;
          end
        end
        ST_WREF: begin
          if (tmr_go) begin
            en_q  <= en_q | (NW'(1) << LPS_STEP_REF);
            idx_q <= 3'(LPS_STEP_REF);
            st_q  <= ST_RCHK;
          end
        end
        ST_RCHK: begin
          if (cur_err) begin
            st_q <= ST_UNW;
          end else begin
            ld_q  <= 1'b1;
            ldv_q <= TW'(SETTLE_US);
            st_q  <= ST_SETL;
          end
        end
        ST_SETL: begin
          if (tmr_go) begin
            ep_q  <= rst_pol_i;
            ld_q  <= 1'b1;
            ldv_q <= TW'(EP_RST_US);
            st_q  <= ST_EPH;
          end
        end
        ST_EPH: begin
          if (tmr_go) begin
            phy_rst_q <= 1'b0;
            st_q      <= ST_POLL;
          end else begin
            ep_q <= rst_pol_i;
          end
        end
        ST_POLL: begin
          if (pll_lock_i) begin
            done_q <= 1'b1;
            st_q   <= ST_UP;
          end else if (rty_last) begin
            lto_q <= 1'b1;
            st_q  <= ST_LTO;
          end else begin
            ld_q  <= 1'b1;
            ldv_q <= TW'(POLL_GAP_US);
            st_q  <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (tmr_go) begin
            st_q <= ST_POLL;
          end
        end
        ST_UNW: begin
          en_q <= en_q & ~idx_mask;
          if (idx_q == '0) begin
            pd_q  <= 1'b1;
            err_q <= 1'b1;
            st_q  <= ST_IDLE;
          end else begin
            idx_q <= idx_q - 3'd1;
          end
        end
        ST_UP, ST_LTO: begin
          st_q <= st_q;
        end
        default: begin
          st_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign supply_en_o   = en_q[0];
  assign phy_clk_en_o  = en_q[1];
  assign bus_clk_en_o  = en_q[2];
  assign core_clk_en_o = en_q[3];
  assign refclk_en_o   = en_q[4];
  assign phy_pd_o      = pd_q;
  assign ep_rst_o      = ep_q;
  assign phy_rst_o     = phy_rst_q;
  assign done_o        = done_q;
  assign lock_to_o     = lto_q;
  assign err_o         = err_q;

endmodule

// File: rtl/lnk_pwr_seq_chk.sv
module lnk_pwr_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       pll_lock_i,
  input logic       rst_pol_i,
  input logic       supply_en_o,
  input logic       phy_clk_en_o,
  input logic       bus_clk_en_o,
  input logic       core_clk_en_o,
  input logic       refclk_en_o,
  input logic       phy_pd_o,
  input logic       ep_rst_o,
  input logic       phy_rst_o,
  input logic       done_o,
  input logic       lock_to_o,
  input logic       err_o
);
  logic [4:0] en;
  assign en = {refclk_en_o, core_clk_en_o, bus_clk_en_o, phy_clk_en_o, supply_en_o};

  for (genvar k = 1; k < 5; k++) begin : g_chain
    // R2: a later step is never on without the one before it
    a_r2_chain_order: assert property (@(posedge clk) disable iff (rst)
      en[k] |-> en[k-1]);
  end

  for (genvar k = 0; k < 4; k++) begin : g_unwind
    // R9: a step only turns off once every later step is already off
    a_r9_reverse_off: assert property (@(posedge clk) disable iff (rst)
      $fell(en[k]) |-> !en[k+1]);
  end

  a_r3_ref_after_pd: assert property (@(posedge clk) disable iff (rst)
    refclk_en_o |-> !phy_pd_o);

  a_r6_phy_rst_with_pin: assert property (@(posedge clk) disable iff (rst)
    $fell(phy_rst_o) |-> (ep_rst_o != rst_pol_i) && $past(ep_rst_o == rst_pol_i));

  a_r5_pin_window: assert property (@(posedge clk) disable iff (rst)
    ($stable(rst_pol_i) && (ep_rst_o == rst_pol_i)) |-> (refclk_en_o && phy_rst_o));

  a_r7_done_on_lock: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(pll_lock_i) && !phy_rst_o);

  a_r8_timeout_no_lock: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_to_o) |-> $past(!pll_lock_i) && !done_o);

  a_r9_err_all_off: assert property (@(posedge clk) disable iff (rst)
    $rose(err_o) |-> (en == 5'd0) && phy_pd_o);

endmodule

bind lnk_pwr_seq lnk_pwr_seq_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .pll_lock_i    (pll_lock_i),
  .rst_pol_i     (rst_pol_i),
  .supply_en_o   (supply_en_o),
  .phy_clk_en_o  (phy_clk_en_o),
  .bus_clk_en_o  (bus_clk_en_o),
  .core_clk_en_o (core_clk_en_o),
  .refclk_en_o   (refclk_en_o),
  .phy_pd_o      (phy_pd_o),
  .ep_rst_o      (ep_rst_o),
  .phy_rst_o     (phy_rst_o),
  .done_o        (done_o),
  .lock_to_o     (lock_to_o),
  .err_o         (err_o)
);

// File: tb/lnk_pwr_seq_bench.sv
module lnk_pwr_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int REF_US     = 3;
  localparam int SET_US     = 5;
  localparam int EPR_US     = 10;
  localparam int PMAX       = 4;
  localparam int GAP_US     = 2;
  localparam int PSTEP      = GAP_US * DIV + 3;
  localparam logic [7:0] NEVER = 8'hFF;

  typedef struct packed {
    logic       pol;
    logic [4:0] fmask;
    logic [7:0] dly;
    logic [1:0] outc;   // 0 done, 1 lock timeout, 2 step error
  } row_t;

  localparam int NROW = 9;
  localparam row_t ROWS [0:NROW-1] = '{
    '{1'b1, 5'b00000, 8'd0,  2'd0},
    '{1'b0, 5'b00000, 8'd15, 2'd0},
    '{1'b1, 5'b00000, NEVER, 2'd1},
    '{1'b0, 5'b00001, 8'd0,  2'd2},
    '{1'b1, 5'b00100, 8'd0,  2'd2},
    '{1'b1, 5'b00000, 8'd11, 2'd0},
    '{1'b0, 5'b00000, 8'd33, 2'd0},
    '{1'b1, 5'b00000, 8'd34, 2'd1},
    '{1'b0, 5'b10000, 8'd0,  2'd2}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       lock = 1'b0;
  logic       pol = 1'b1;
  logic [4:0] fmask = 5'd0;
  logic       supply_en, phy_clk_en, bus_clk_en, core_clk_en, refclk_en;
  logic       phy_pd, ep_rst, phy_rst, done, lock_to, err;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  lnk_pwr_seq #(
    .TICK_DIV(DIV), .REF_DLY_US(REF_US), .SETTLE_US(SET_US),
    .EP_RST_US(EPR_US), .POLL_MAX(PMAX), .POLL_GAP_US(GAP_US)
  ) u_lnk_pwr_seq (
    .clk(clk), .rst(rst), .start_i(start), .pll_lock_i(lock),
    .rst_pol_i(pol), .step_err_i(fmask),
    .supply_en_o(supply_en), .phy_clk_en_o(phy_clk_en),
    .bus_clk_en_o(bus_clk_en), .core_clk_en_o(core_clk_en),
    .refclk_en_o(refclk_en), .phy_pd_o(phy_pd), .ep_rst_o(ep_rst),
    .phy_rst_o(phy_rst), .done_o(done), .lock_to_o(lock_to), .err_o(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Event monitor: 0..4 enables, 5 pd, 6 pin active, 7 phy rst, 8 done, 9 timeout
  logic       mon_clr = 1'b1;
  logic [9:0] sig, prev;
  int         t_rise [10];
  int         t_fall [10];
  assign sig = {lock_to, done, phy_rst, (ep_rst == pol), phy_pd,
                refclk_en, core_clk_en, bus_clk_en, phy_clk_en, supply_en};

  always @(negedge clk) begin
    if (mon_clr) begin
      for (int i = 0; i < 10; i++) begin
        t_rise[i] = -1;
        t_fall[i] = -1;
      end
    end else begin
      for (int i = 0; i < 10; i++) begin
        if (sig[i] && !prev[i]) t_rise[i] = cyc;
        if (!sig[i] && prev[i]) t_fall[i] = cyc;
      end
    end
    prev = sig;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic p);
    pol = p;
    rst = 1'b1;
    mon_clr = 1'b1;
    lock = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    mon_clr = 1'b0;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_row(input row_t r);
    int since;
    int j;
    int exp_done;
    int k;
    do_reset(r.pol);
    fmask = r.fmask;
    // R1 reset / idle state
    chk({supply_en, phy_clk_en, bus_clk_en, core_clk_en, refclk_en} == 5'd0, "R1 enables off", 0, 0);
    chk(phy_pd && phy_rst && !done && !lock_to && !err, "R1 pd/rst/flags", int'(phy_pd), 1);
    chk(ep_rst == ~r.pol, "R1 idle pin level", int'(ep_rst), int'(~r.pol));
    pulse_start();
    since = 0;
    for (int c = 0; c < 600; c++) begin
      if (!phy_rst) begin
        if (r.dly != NEVER && since == int'(r.dly)) lock = 1'b1;
        since++;
      end
      if (done || lock_to || err) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);

    if (r.outc == 2'd2) begin
      k = 0;
      for (int b = 0; b < 5; b++) if (r.fmask[b]) k = b;
      chk(err && !done && !lock_to, "R9 error flag", int'(err), 1);
      chk({supply_en, phy_clk_en, bus_clk_en, core_clk_en, refclk_en} == 5'd0 && phy_pd,
          "R9 all off and powered down", int'(phy_pd), 1);
      chk(t_fall[k] - t_rise[k] == 2, "R9 first off two cycles after rise", t_fall[k] - t_rise[k], 2);
      for (int b = 0; b < k; b++)
        chk(t_fall[b] - t_fall[b+1] == 1, "R9 reverse order", t_fall[b] - t_fall[b+1], 1);
      for (int b = k + 1; b < 5; b++)
        chk(t_rise[b] == -1, "R9 later step never on", t_rise[b], -1);
      chk(t_rise[6] == -1 && ep_rst == ~r.pol, "R9 endpoint reset untouched", t_rise[6], -1);
    end else begin
      chk(t_rise[1] - t_rise[0] == 1 && t_rise[2] - t_rise[1] == 1 && t_rise[3] - t_rise[2] == 1,
          "R2 enable order", t_rise[3] - t_rise[0], 3);
      chk(t_fall[5] - t_rise[3] == 1, "R3 pd release", t_fall[5] - t_rise[3], 1);
      chk(t_rise[4] - t_fall[5] == REF_US * DIV + 2, "R3 refclk delay",
          t_rise[4] - t_fall[5], REF_US * DIV + 2);
      chk(t_rise[6] - t_rise[4] == SET_US * DIV + 3, "R4 settle wait",
          t_rise[6] - t_rise[4], SET_US * DIV + 3);
      chk(t_fall[6] - t_rise[6] == EPR_US * DIV + 2, "R5 pulse width",
          t_fall[6] - t_rise[6], EPR_US * DIV + 2);
      chk(ep_rst == ~r.pol, "R5 pin back at inactive level", int'(ep_rst), int'(~r.pol));
      chk(t_fall[7] == t_fall[6], "R6 phy reset release", t_fall[7], t_fall[6]);
      j = (r.dly == NEVER) ? PMAX : (int'(r.dly) + PSTEP - 1) / PSTEP;
      if (r.outc == 2'd0) begin
        exp_done = 1 + PSTEP * j;
        chk(done && !lock_to && !err, "R7 done flag", int'(done), 1);
        chk(t_rise[8] - t_fall[7] == exp_done, "R7 lock poll timing", t_rise[8] - t_fall[7], exp_done);
      end else begin
        exp_done = 1 + PSTEP * (PMAX - 1);
        chk(lock_to && !done, "R8 timeout flag", int'(lock_to), 1);
        chk(t_rise[9] - t_fall[7] == exp_done, "R8 timeout timing", t_rise[9] - t_fall[7], exp_done);
        chk({supply_en, phy_clk_en, bus_clk_en, core_clk_en, refclk_en} == 5'h1F,
            "R8 enables kept", 0, 31);
      end
    end
  endtask

  initial begin
    fmask = 5'd0;
    for (int i = 0; i < NROW; i++) run_row(ROWS[i]);

    // R10: restart after a failure clears the error and runs to completion
    fmask = 5'd0;
    lock = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!err && supply_en, "R10 restart clears error", int'(err), 0);
    for (int c = 0; c < 400 && !done; c++) @(negedge clk);
    chk(done, "R10 restart reaches done", int'(done), 1);

    // R10: start after done changes nothing
    pulse_start();
    repeat (5) @(negedge clk);
    chk(done && !phy_rst && {supply_en, phy_clk_en, bus_clk_en, core_clk_en, refclk_en} == 5'h1F,
        "R10 start ignored when up", int'(done), 1);

    // R1: strap change while idle is followed on the pin
    do_reset(1'b1);
    pol = 1'b0;
    repeat (2) @(negedge clk);
    chk(ep_rst == 1'b1, "R1 pin follows strap in idle", int'(ep_rst), 1);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", n_chk + 1, n_err + 1);
    $finish;
  end
endmodule